// File: doc/BRIEF.md
# L1 Cache Refill and Write-Through Controller

This block is the one sequencer that sits between a pair of level-one caches and the external SDRAM controller. One cache holds instructions and the other holds data. When the instruction side reports a miss, the block fetches the whole line from memory as one burst. It writes that line into the instruction array with its valid bit set and hands back the word that was asked for. The data side gets the same refill service for read misses.

Data stores go through to memory as single-word writes. If the store address is already resident, the controller also patches the matching word of the cached line. A store to an address that is not resident leaves both arrays alone. A clear command sweeps every line of both caches and drops the valid bits, one index per cycle. This is used after new code has been placed in memory.

Requesters hold their request level and stay stalled until the one-cycle completion pulse. When several requests are pending, they are served from a single idle state in this order: clear first, then data, then instruction. The arrays themselves and the memory controller live outside the block.

Top module: `l1_fill_ctrl`

## Requirements
- R1: After reset, with no request pending, `mem_req`, `ic_we`, `dc_we`, `ic_vclr`, `dc_vclr`, `done`, `i_stall` and `d_stall` are all low.
- R2: An instruction miss issues one memory read (`mem_we`=0) of line `i_addr >> log2(WORDS)`. In the `done` cycle, `ic_we` is high and `arr_wmask` is all ones. `arr_idx` equals address bits [OW+IW-1:OW] and `arr_tag` equals the upper address bits. `arr_line` is the returned line, `resp_word` is word `i_addr[OW-1:0]` of that line, and `i_stall` is low.
- R3: A data read miss behaves like R2, but the line goes to the data array through `dc_we`, and `ic_we` stays low.
- R4: A data write issues one memory write (`mem_we`=1) with `mem_line`, `mem_off` and `mem_wdata` taken from the request. `d_stall` stays high from the request until the `done` cycle.
- R5: On a write that the requester marks resident (`d_hit`=1), `dc_we` is high in the `done` cycle. `arr_wmask` then has only bit `mem_off` set, and that word of `arr_line` holds the write data.
- R6: On a write with `d_hit`=0, neither `ic_we` nor `dc_we` rises at any point of the operation.
- R7: When instruction and data requests are pending in the same cycle, the data request completes first and the instruction request completes afterwards.
- R8: A clear drives `ic_vclr` and `dc_vclr` together for exactly LINES consecutive cycles, with `arr_idx` running 0, 1, …, LINES-1 in order. No memory request is made during the sweep. Both stalls stay high until the `done` that ends the sweep.
- R9: A clear request takes precedence over a data request pending in the same cycle.
- R10: `done` is high for exactly one cycle per completed operation.
- R11: Once raised, `mem_req` stays high with a stable `mem_line` and `mem_we` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_req | input | 1 | Instruction miss pending (held until done) |
| i_addr | input | AW | Instruction word address |
| d_req | input | 1 | Data request pending (held until done) |
| d_we | input | 1 | Data request is a write |
| d_addr | input | AW | Data word address |
| d_wdata | input | DW | Store data |
| d_hit | input | 1 | Store address is resident in the data cache |
| clr_req | input | 1 | Invalidate both caches (held until done) |
| i_stall | output | 1 | Instruction side must wait |
| d_stall | output | 1 | Data side must wait |
| done | output | 1 | One-cycle completion pulse |
| resp_word | output | DW | Requested word, valid with done on reads |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a single-word write |
| mem_line | output | AW-log2(WORDS) | Line address |
| mem_off | output | log2(WORDS) | Word offset (writes) |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Memory request complete |
| mem_rdata | input | WORDS*DW | Burst line, valid with mem_ack |
| ic_we | output | 1 | Instruction array line write, sets valid |
| dc_we | output | 1 | Data array line write, sets valid |
| ic_vclr | output | 1 | Instruction array valid clear |
| dc_vclr | output | 1 | Data array valid clear |
| arr_idx | output | log2(LINES) | Array line index |
| arr_tag | output | AW-log2(WORDS)-log2(LINES) | Tag to store |
| arr_wmask | output | WORDS | Word enables for the line write |
| arr_line | output | WORDS*DW | Line contents to store |

## Verification
The bench builds the block with LINES=16 and AW=16, keeping the 8-word line and 32-bit word. The shorter index makes a complete clear sweep only sixteen cycles long, so the whole ordered index sequence can be checked every time. The narrower address still leaves a 9-bit tag, which lets the tests pick addresses that spread across index, tag and word-offset fields and catch any misplaced slice.

// File: rtl/l1_fill_ctrl.sv
module l1_fill_ctrl #(
  parameter  int AW    = 26,
  parameter  int DW    = 32,
  parameter  int WORDS = 8,
  parameter  int LINES = 128,
  localparam int OW    = $clog2(WORDS),
  localparam int IW    = $clog2(LINES),
  localparam int LW    = AW - OW,
  localparam int TW    = AW - OW - IW,
  localparam int LB    = WORDS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_req,
  input  logic [AW-1:0] i_addr,
  input  logic          d_req,
  input  logic          d_we,
  input  logic [AW-1:0] d_addr,
  input  logic [DW-1:0] d_wdata,
  input  logic          d_hit,
  input  logic          clr_req,
  output logic          i_stall,
  output logic          d_stall,
  output logic          done,
  output logic [DW-1:0] resp_word,
  output logic          mem_req,
  output logic          mem_we,
  output logic [LW-1:0] mem_line,
  output logic [OW-1:0] mem_off,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [LB-1:0] mem_rdata,
  output logic          ic_we,
  output logic          dc_we,
  output logic          ic_vclr,
  output logic          dc_vclr,
  output logic [IW-1:0] arr_idx,
  output logic [TW-1:0] arr_tag,
  output logic [WORDS-1:0] arr_wmask,
  output logic [LB-1:0] arr_line
);

  typedef enum logic [2:0] {S_IDLE, S_IFILL, S_DFILL, S_DWR, S_CLR, S_FIN} st_t;
  typedef enum logic [1:0] {OP_I, OP_D, OP_W, OP_C} op_t;

  st_t           st;
  op_t           op;
  logic [AW-1:0] addr_q;
  logic          hit_q;
  logic [LB-1:0] line_q;
  logic [IW-1:0] cnt;

  wire [OW-1:0] off    = addr_q[OW-1:0];
  wire          fin    = (st == S_FIN);
  wire          fin_i  = fin && (op == OP_I);
  wire          fin_d  = fin && (op == OP_D || op == OP_W);
  wire          fin_c  = fin && (op == OP_C);
  wire          in_clr = (st == S_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op     <= OP_I;
      addr_q <= '0;
      hit_q  <= 1'b0;
      line_q <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (clr_req) begin
            st  <= S_CLR;
            op  <= OP_C;
            cnt <= '0;
          end else if (d_req) begin
            addr_q <= d_addr;
            hit_q  <= d_hit;
            line_q <= {WORDS{d_wdata}};
            op     <= d_we ? OP_W : OP_D;
            st     <= d_we ? S_DWR : S_DFILL;
          end else if (i_req) begin
            addr_q <= i_addr;
            op     <= OP_I;
            st     <= S_IFILL;
          end
        end
        S_IFILL, S_DFILL: if (mem_ack) begin
          line_q <= mem_rdata;
          st     <= S_FIN;
        end
        S_DWR: if (mem_ack) st <= S_FIN;
        S_CLR: begin
          cnt <= cnt + 1'b1;
          if (cnt == IW'(LINES - 1)) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_IFILL) || (st == S_DFILL) || (st == S_DWR);
  assign mem_we    = (st == S_DWR);
  assign mem_line  = addr_q[AW-1:OW];
  assign mem_off   = off;
  assign mem_wdata = line_q[DW-1:0];

  assign ic_we     = fin_i;
  assign dc_we     = fin && (op == OP_D || (op == OP_W && hit_q));
  assign ic_vclr   = in_clr;
  assign dc_vclr   = in_clr;
  assign arr_idx   = in_clr ? cnt : addr_q[OW +: IW];
  assign arr_tag   = addr_q[AW-1 -: TW];
  assign arr_wmask = (op == OP_W) ? (WORDS'(1) << off) : '1;
  assign arr_line  = line_q;

  assign done      = fin;
  assign resp_word = line_q[off*DW +: DW];

  assign i_stall = (i_req && !fin_i) || (clr_req && !fin_c) || in_clr;
  assign d_stall = (d_req && !fin_d) || (clr_req && !fin_c) || in_clr;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line) && $stable(mem_we))); // R11
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ic_vclr |-> (!mem_req && !ic_we && !dc_we && dc_vclr)); // R8
  AST_IFILL_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ic_we |-> (&arr_wmask)); // R2
  AST_WR_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_we && $past(mem_we)) |-> ($countones(arr_wmask) == 1)); // R5
  AST_WR_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_we && mem_ack) && done) |-> !ic_we); // R6

endmodule

// File: tb/l1_fill_ctrl_tb.sv
`timescale 1ns/1ps
module l1_fill_ctrl_tb;
  localparam int AW = 16, DW = 32, WORDS = 8, LINES = 16;
  localparam int OW = $clog2(WORDS), IW = $clog2(LINES);
  localparam int LW = AW - OW, TW = AW - OW - IW, LB = WORDS * DW;

  logic clk = 0, rst_n = 0;
  logic i_req = 0, d_req = 0, d_we = 0, d_hit = 0, clr_req = 0;
  logic [AW-1:0] i_addr = '0, d_addr = '0;
  logic [DW-1:0] d_wdata = '0;
  logic i_stall, d_stall, done, mem_req, mem_we, mem_ack, ic_we, dc_we, ic_vclr, dc_vclr;
  logic [DW-1:0] resp_word, mem_wdata;
  logic [LW-1:0] mem_line;
  logic [OW-1:0] mem_off;
  logic [LB-1:0] mem_rdata, arr_line;
  logic [IW-1:0] arr_idx;
  logic [TW-1:0] arr_tag;
  logic [WORDS-1:0] arr_wmask;

  always #2 clk = ~clk;

  l1_fill_ctrl #(.AW(AW), .DW(DW), .WORDS(WORDS), .LINES(LINES)) u_dut (
    .clk, .rst_n, .i_req, .i_addr, .d_req, .d_we, .d_addr, .d_wdata, .d_hit, .clr_req,
    .i_stall, .d_stall, .done, .resp_word, .mem_req, .mem_we, .mem_line, .mem_off,
    .mem_wdata, .mem_ack, .mem_rdata, .ic_we, .dc_we, .ic_vclr, .dc_vclr, .arr_idx,
    .arr_tag, .arr_wmask, .arr_line);

  int checks = 0, errors = 0;

  function automatic logic [LB-1:0] mk_line(input logic [LW-1:0] ln);
    logic [LB-1:0] r;
    for (int w = 0; w < WORDS; w++) r[w*DW +: DW] = {3'b101, ln, 16'(w)};
    return r;
  endfunction

  assign mem_rdata = mk_line(mem_line);

  // memory stub: acknowledges after a few cycles and records the request
  int lat = 0, mem_ops = 0;
  logic [LW-1:0] rec_line;
  logic [OW-1:0] rec_off;
  logic [DW-1:0] rec_wdata;
  logic rec_we;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; lat <= 0;
    end else begin
      mem_ack <= 0;
      if (mem_req && !mem_ack) begin
        if (lat == 3) begin
          mem_ack <= 1; lat <= 0; mem_ops <= mem_ops + 1;
          rec_line <= mem_line; rec_off <= mem_off; rec_wdata <= mem_wdata; rec_we <= mem_we;
        end else lat <= lat + 1;
      end
    end
  end

  // monitor
  int arr_wr = 0, vclr_cnt = 0, vclr_err = 0, dbl_done = 0, hold_err = 0;
  logic p_req = 0, p_ack = 0, p_done = 0;
  logic [LW-1:0] p_line = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ic_we || dc_we) arr_wr++;
      if (ic_vclr) begin
        if (!dc_vclr || arr_idx != IW'(vclr_cnt)) vclr_err++;
        vclr_cnt++;
      end
      if (done && p_done) dbl_done++;
      if (p_req && !p_ack && (!mem_req || mem_line != p_line)) hold_err++;
    end
    p_req = mem_req; p_ack = mem_ack; p_done = done; p_line = mem_line;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(input bit watch_i, input bit watch_d, output int bad);
    int t = 0;
    bad = 0;
    do begin
      @(negedge clk);
      t++;
      if (!done && ((watch_i && !i_stall) || (watch_d && !d_stall))) bad++;
    end while (!done && t < 1000);
    if (t >= 1000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", t);
    end
  endtask

  task automatic do_read(input bit is_i, input logic [AW-1:0] a);
    int bad;
    logic [LW-1:0] ln = a[AW-1:OW];
    logic [LB-1:0] exp_line = mk_line(ln);
    @(negedge clk); #1;
    arr_wr = 0;
    if (is_i) begin i_req = 1; i_addr = a; end
    else begin d_req = 1; d_we = 0; d_addr = a; end
    wait_done(is_i, !is_i, bad);
    chk(bad == 0, is_i ? "R2 stall held" : "R3 stall held", bad, 0);
    chk(rec_line == ln && !rec_we, is_i ? "R2 mem line" : "R3 mem line", rec_line, ln);
    chk(resp_word == exp_line[a[OW-1:0]*DW +: DW], is_i ? "R2 word" : "R3 word",
        resp_word, exp_line[a[OW-1:0]*DW +: DW]);
    chk(ic_we == is_i && dc_we == !is_i, is_i ? "R2 array" : "R3 array", {ic_we, dc_we}, {is_i, !is_i});
    chk(arr_idx == a[OW +: IW] && arr_tag == a[AW-1 -: TW] && &arr_wmask && arr_line == exp_line,
        is_i ? "R2 idx/tag/line" : "R3 idx/tag/line", {arr_idx, arr_tag}, {a[OW +: IW], a[AW-1 -: TW]});
    chk(is_i ? !i_stall : !d_stall, is_i ? "R2 release" : "R3 release", is_i ? i_stall : d_stall, 0);
    #1; i_req = 0; d_req = 0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v, input bit hit);
    int bad;
    @(negedge clk); #1;
    arr_wr = 0;
    d_req = 1; d_we = 1; d_addr = a; d_wdata = v; d_hit = hit;
    wait_done(0, 1, bad);
    chk(bad == 0, "R4 d_stall held", bad, 0);
    chk(rec_we && rec_line == a[AW-1:OW] && rec_off == a[OW-1:0] && rec_wdata == v,
        "R4 mem write", rec_wdata, v);
    if (hit) begin
      chk(dc_we && !ic_we && arr_wmask == WORDS'(1) << a[OW-1:0], "R5 mask", arr_wmask,
          WORDS'(1) << a[OW-1:0]);
      chk(arr_line[a[OW-1:0]*DW +: DW] == v && arr_idx == a[OW +: IW], "R5 word",
          arr_line[a[OW-1:0]*DW +: DW], v);
    end else begin
      #1;
      chk(arr_wr == 0, "R6 no array write", arr_wr, 0);
    end
    d_req = 0; d_we = 0; d_hit = 0;
  endtask

  task automatic do_priority(input logic [AW-1:0] ia, input logic [AW-1:0] da);
    int bad;
    @(negedge clk); #1;
    i_req = 1; i_addr = ia; d_req = 1; d_we = 0; d_addr = da;
    wait_done(1, 1, bad);
    chk(dc_we && !ic_we && rec_line == da[AW-1:OW], "R7 data first", {ic_we, dc_we}, 2'b01);
    chk(bad == 0, "R7 both stalled", bad, 0);
    #1; d_req = 0;
    wait_done(1, 0, bad);
    chk(ic_we && rec_line == ia[AW-1:OW] && bad == 0, "R7 instr second", rec_line, ia[AW-1:OW]);
    #1; i_req = 0;
  endtask

  task automatic do_clear(input logic [AW-1:0] da);
    int bad, ops0;
    @(negedge clk); #1;
    vclr_cnt = 0; vclr_err = 0; ops0 = mem_ops;
    clr_req = 1; d_req = 1; d_we = 0; d_addr = da;
    wait_done(1, 1, bad);
    chk(vclr_cnt == LINES, "R8 sweep length", vclr_cnt, LINES);
    chk(vclr_err == 0, "R8 sweep order", vclr_err, 0);
    chk(bad == 0, "R8 stalls held", bad, 0);
    chk(mem_ops == ops0 && !dc_we, "R9 clear before data", mem_ops, ops0);
    #1; clr_req = 0;
    wait_done(0, 1, bad);
    chk(dc_we && rec_line == da[AW-1:OW], "R9 data after clear", dc_we, 1);
    #1; d_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_req && !ic_we && !dc_we && !ic_vclr && !dc_vclr && !done && !i_stall && !d_stall,
        "R1 reset state", {mem_req, ic_we, dc_we, done, i_stall, d_stall}, 0);
    do_read(1, 16'h1234);
    do_read(1, 16'hFFFF);
    do_read(0, 16'h0000);
    do_read(0, 16'hA5C3);
    do_write(16'h3B6A, 32'hDEADBEEF, 1);
    do_write(16'h0007, 32'h12345678, 1);
    do_write(16'h7E11, 32'hCAFEF00D, 0);
    do_priority(16'h0440, 16'h9987);
    do_clear(16'h5A5D);
    do_clear(16'h0102);
    repeat (3) @(negedge clk);
    chk(dbl_done == 0, "R10 done single cycle", dbl_done, 0);
    chk(hold_err == 0, "R11 request held", hold_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule